// File: doc/BRIEF.md
# Packet-Protocol Storage Device Controller

This block is the device end of a parallel storage-attachment register file. It also runs the state machine for the packet command protocol. A host drives byte-wide register reads and writes and a 16-bit data port. The controller moves through four phases in turn: accepting a 12-byte command packet, working, handing data to the host, and reporting completion. At each step it sets the status, interrupt-reason and byte-count encodings the host expects, and it drives a level interrupt line. It also takes three direct commands: a device reset that loads a fixed signature, set-features, and the packet command. Any other command is aborted.

A small built-in responder stands in for the media. Packet byte 0 is the operation code. Codes 0xF0 to 0xFF fail, with the sense key taken from the low nibble. Any other code returns a data block. Its length in bytes comes from packet bytes 3 (high) and 4 (low), with bit 0 forced to zero. Data word k of a transfer reads k XOR `PATTERN`. Long transfers are split into blocks of `BLK_BYTES`. A separate configuration write, compared against `ENABLE_KEY`, switches the whole interface on or off.

Register reads are combinational from the current state. Their side effects take place at the clock edge that ends the read strobe. The data port has no back-pressure: it is a DRQ phase, and the host may read one word on each cycle of that phase.

Top module: `atapi_dev_ctrl`

## Requirements
- R1: A write of 0xA0 to the command register (address 6) starts the packet phase. Status and alternate status (address 7) read 0x58, count (address 2) reads 0x01, the byte-count registers (address 3 low, address 4 high) keep their host-written values, and INTRQ stays low for the whole phase.
- R2: The packet phase takes six writes to the data port (address 0). Packet byte 2n is the low byte of word n. After the sixth write, status reads 0xD0 for `BUSY_CYC` cycles, and then the next phase begins with INTRQ raised.
- R3: In the data-in phase, status reads 0x58, count reads 0x02, and the byte-count registers hold the size of the current block, split into a low byte and a high byte.
- R4: A transfer is split into blocks of `BLK_BYTES` (default 2048), with the remainder in a final short block. INTRQ is raised again only after a whole block has been read, and it stays low while words of the block remain.
- R5: Data word k of a transfer, counted across blocks, reads k XOR `PATTERN` (default 0xA5C3). The transfer length is {byte 3, byte 4} with bit 0 cleared.
- R6: When a transfer finishes, or at once if its length is zero, status reads 0x50, count reads 0x03, and INTRQ is raised.
- R7: Operation codes 0xF0 to 0xFF fail. Status reads 0x51, count reads 0x03, the error register (address 1) holds the code's low nibble in bits 7:4, and INTRQ is raised.
- R8: Command 0x08, and also power-on, leave status 0x00, error 0x01, count 0x01, byte count 0x14 (low) and 0xEB (high), data port 0xFFFF, and INTRQ low.
- R9: Command 0xEF with a feature value (address 1 write) of 0x03 leaves status 0x50, count as written, both byte-count registers 0x00, and INTRQ low. Any other feature value aborts, as in R10.
- R10: Any other command code aborts: status 0x51, error 0x04, INTRQ raised.
- R11: While the interface is disabled, every read returns 0xFFFF and register writes are ignored. A configuration write equal to `ENABLE_KEY` enables the interface, and any other value disables it.
- R12: Reading status clears INTRQ. Reading alternate status returns the same byte and leaves INTRQ as it was.
- R13: A command write while status has bit 7 (BSY) set is ignored.
- R14: A data-port read outside the data-in phase returns 0xFFFF and does not advance the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register select: 0 data, 1 error/feature, 2 count, 3 byte count low, 4 byte count high, 5 device, 6 status/command, 7 alternate status |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| reg_rdata | output | 16 | Read data; byte registers are zero-extended |
| intrq | output | 1 | Level interrupt request to the host |
| cfg_wr | input | 1 | Interface enable/disable write strobe |
| cfg_data | input | 32 | Value compared with `ENABLE_KEY` |

## Verification
The transfer sweep covers these lengths: zero, a single word, a short block, one word under a block, exactly one block, one word over a block, and several blocks with a short tail. Together they separate the no-data path, the block-size rounding and the boundary where a new block starts. The first word of every block is checked after a data read made during the busy gap, so a port that advances outside DRQ shifts every later word. All sixteen failing operation codes are swept to confirm where the sense key is placed in the error register. The direct commands are tried with good and bad feature values, with an unknown code, and during BSY, and each leaves a distinct register picture.

// File: rtl/atapi_pkg.sv
package atapi_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_ERR  = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;
  localparam logic [2:0] A_BCL  = 3'd3;
  localparam logic [2:0] A_BCH  = 3'd4;
  localparam logic [2:0] A_DEV  = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;
  localparam logic [2:0] A_ALT  = 3'd7;

  localparam logic [7:0] CMD_PACKET  = 8'hA0;
  localparam logic [7:0] CMD_RESET   = 8'h08;
  localparam logic [7:0] CMD_SETFEAT = 8'hEF;
  localparam logic [7:0] FEAT_PIO    = 8'h03;

  localparam logic [7:0] ST_RESET = 8'h00;
  localparam logic [7:0] ST_DRQ   = 8'h58;
  localparam logic [7:0] ST_BSY   = 8'hD0;
  localparam logic [7:0] ST_RDY   = 8'h50;
  localparam logic [7:0] ST_ERR   = 8'h51;

  localparam logic [7:0] IR_CMD  = 8'h01;
  localparam logic [7:0] IR_DIN  = 8'h02;
  localparam logic [7:0] IR_DONE = 8'h03;
  localparam logic [7:0] ERR_ABORT = 8'h04;

  localparam logic [7:0] SIG_ERR = 8'h01;
  localparam logic [7:0] SIG_CNT = 8'h01;
  localparam logic [7:0] SIG_BCL = 8'h14;
  localparam logic [7:0] SIG_BCH = 8'hEB;

  typedef enum logic [1:0] {PH_IDLE, PH_PKT, PH_BUSY, PH_DIN} phase_e;

  typedef struct packed {
    logic sig;
    logic pkt;
    logic blk;
    logic done;
    logic err;
    logic abrt;
    logic feat;
  } tf_ev_t;
endpackage

// File: rtl/atapi_resp.sv
module atapi_resp
  #(parameter logic [15:0] PATTERN = 16'hA5C3)
  (
  input  logic [7:0]  op,
  input  logic [7:0]  len_hi,
  input  logic [7:0]  len_lo,
  input  logic [15:0] widx,
  output logic        fail,
  output logic [3:0]  sense,
  output logic [15:0] xfer_len,
  output logic [15:0] word
);
  always_comb begin
    fail     = (op[7:4] == 4'hF);
    sense    = op[3:0];
    xfer_len = {len_hi, len_lo} & 16'hFFFE;
    word     = widx ^ PATTERN;
  end
endmodule

// File: rtl/atapi_taskfile.sv
module atapi_taskfile
  import atapi_pkg::*;
  (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_data,
  input  tf_ev_t      ev,
  input  logic [3:0]  sense,
  input  logic [15:0] blk_bytes,
  output logic [7:0]  err_q,
  output logic [7:0]  feat_q,
  output logic [7:0]  cnt_q,
  output logic [7:0]  bcl_q,
  output logic [7:0]  bch_q,
  output logic [7:0]  dev_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= SIG_ERR;
      feat_q <= 8'h00;
      cnt_q  <= SIG_CNT;
      bcl_q  <= SIG_BCL;
      bch_q  <= SIG_BCH;
      dev_q  <= 8'h00;
    end else begin
      // host writes first; device events below take priority
      if (host_wr) begin
        unique case (host_addr)
          A_ERR:   feat_q <= host_data;
          A_CNT:   cnt_q  <= host_data;
          A_BCL:   bcl_q  <= host_data;
          A_BCH:   bch_q  <= host_data;
          A_DEV:   dev_q  <= host_data;
          default: ;
        endcase
      end
      if (ev.sig) begin
        err_q <= SIG_ERR;
        cnt_q <= SIG_CNT;
        bcl_q <= SIG_BCL;
        bch_q <= SIG_BCH;
      end
      if (ev.pkt) begin
        cnt_q <= IR_CMD;
        err_q <= 8'h00;
      end
      if (ev.blk) begin
        cnt_q <= IR_DIN;
        bcl_q <= blk_bytes[7:0];
        bch_q <= blk_bytes[15:8];
      end
      if (ev.done) begin
        cnt_q <= IR_DONE;
        err_q <= 8'h00;
      end
      if (ev.err) begin
        cnt_q <= IR_DONE;
        err_q <= {sense, 4'h0};
      end
      if (ev.abrt) err_q <= ERR_ABORT;
      if (ev.feat) begin
        err_q <= 8'h00;
        bcl_q <= 8'h00;
        bch_q <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/atapi_seq.sv
module atapi_seq
  import atapi_pkg::*;
  #(parameter int BLK_BYTES = 2048,
    parameter int BUSY_CYC  = 4)
  (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_go,
  input  logic [7:0]  cmd_code,
  input  logic [7:0]  feat,
  input  logic        pkt_wr_go,
  input  logic        din_rd_go,
  input  logic [15:0] wdata,
  input  logic        resp_fail,
  input  logic [15:0] resp_len,
  output phase_e      phase,
  output logic [7:0]  status,
  output logic [15:0] widx,
  output logic [7:0]  op,
  output logic [7:0]  len_hi,
  output logic [7:0]  len_lo,
  output tf_ev_t      ev,
  output logic [15:0] blk_bytes,
  output logic        irq_set
);
  localparam int BW = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);
  localparam logic [BW-1:0] BUSY_LD = BW'(BUSY_CYC - 1);
  localparam logic [15:0]   BLK16   = 16'(BLK_BYTES);

  phase_e        phase_q, phase_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [2:0]    pcnt_q, pcnt_d;
  logic [7:0]    op_q, op_d, lhi_q, lhi_d, llo_q, llo_d, istat_q, istat_d;
  logic [15:0]   rem_q, rem_d, bleft_q, bleft_d, widx_q, widx_d, rem_n;
  logic          fresh_q, fresh_d;

  always_comb begin
    phase_d = phase_q; bcnt_d = bcnt_q; pcnt_d = pcnt_q;
    op_d = op_q; lhi_d = lhi_q; llo_d = llo_q; istat_d = istat_q;
    rem_d = rem_q; bleft_d = bleft_q; widx_d = widx_q; fresh_d = fresh_q;
    ev = '0; irq_set = 1'b0; blk_bytes = '0;
    rem_n = fresh_q ? resp_len : rem_q;
    unique case (phase_q)
      PH_PKT: if (pkt_wr_go) begin
        unique case (pcnt_q)
          3'd0:    op_d  = wdata[7:0];
          3'd1:    lhi_d = wdata[15:8];
          3'd2:    llo_d = wdata[7:0];
          default: ;
        endcase
        if (pcnt_q == 3'd5) begin
          phase_d = PH_BUSY; bcnt_d = BUSY_LD; fresh_d = 1'b1;
          pcnt_d = 3'd0; widx_d = '0;
        end else begin
          pcnt_d = pcnt_q + 3'd1;
        end
      end
      PH_BUSY: if (bcnt_q != '0) begin
        bcnt_d = bcnt_q - BW'(1);
      end else begin
        fresh_d = 1'b0;
        irq_set = 1'b1;
        if (fresh_q && resp_fail) begin
          phase_d = PH_IDLE; istat_d = ST_ERR; ev.err = 1'b1;
        end else if (rem_n == '0) begin
          phase_d = PH_IDLE; istat_d = ST_RDY; ev.done = 1'b1;
        end else begin
          blk_bytes = (rem_n > BLK16) ? BLK16 : rem_n;
          phase_d   = PH_DIN;
          bleft_d   = {1'b0, blk_bytes[15:1]};
          rem_d     = rem_n - blk_bytes;
          ev.blk    = 1'b1;
        end
      end
      PH_DIN: if (din_rd_go) begin
        widx_d  = widx_q + 16'd1;
        bleft_d = bleft_q - 16'd1;
        if (bleft_q == 16'd1) begin
          phase_d = PH_BUSY; bcnt_d = BUSY_LD;
        end
      end
      default: ;
    endcase
    if (cmd_go) begin
      pcnt_d = 3'd0;
      if (cmd_code == CMD_PACKET) begin
        phase_d = PH_PKT; ev.pkt = 1'b1;
      end else if (cmd_code == CMD_RESET) begin
        phase_d = PH_IDLE; istat_d = ST_RESET; ev.sig = 1'b1;
      end else if (cmd_code == CMD_SETFEAT && feat == FEAT_PIO) begin
        phase_d = PH_IDLE; istat_d = ST_RDY; ev.feat = 1'b1;
      end else begin
        phase_d = PH_IDLE; istat_d = ST_ERR; ev.abrt = 1'b1; irq_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; bcnt_q <= '0; pcnt_q <= '0;
      op_q <= '0; lhi_q <= '0; llo_q <= '0; istat_q <= ST_RESET;
      rem_q <= '0; bleft_q <= '0; widx_q <= '0; fresh_q <= 1'b0;
    end else begin
      phase_q <= phase_d; bcnt_q <= bcnt_d; pcnt_q <= pcnt_d;
      op_q <= op_d; lhi_q <= lhi_d; llo_q <= llo_d; istat_q <= istat_d;
      rem_q <= rem_d; bleft_q <= bleft_d; widx_q <= widx_d; fresh_q <= fresh_d;
    end
  end

  always_comb begin
    phase  = phase_q;
    widx   = widx_q;
    op     = op_q;
    len_hi = lhi_q;
    len_lo = llo_q;
    unique case (phase_q)
      PH_PKT, PH_DIN: status = ST_DRQ;
      PH_BUSY:        status = ST_BSY;
      default:        status = istat_q;
    endcase
  end
endmodule

// File: rtl/atapi_dev_ctrl.sv
module atapi_dev_ctrl
  import atapi_pkg::*;
  #(parameter int          BLK_BYTES  = 2048,
    parameter int          BUSY_CYC   = 4,
    parameter logic [15:0] PATTERN    = 16'hA5C3,
    parameter logic [31:0] ENABLE_KEY = 32'h5A5A_0001)
  (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        intrq,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_data
);
  logic        en_q, wr_ok, rd_ok, bsy, pkt_phase, din_phase;
  logic        cmd_go, pkt_wr_go, din_rd_go, stat_rd_go, alt_rd_go, irq_set;
  logic        resp_fail;
  logic [3:0]  sense;
  logic [7:0]  status, op, len_hi, len_lo;
  logic [7:0]  err_q, feat_q, cnt_q, bcl_q, bch_q, dev_q;
  logic [15:0] widx, resp_len, resp_word, blk_bytes, mux_data;
  phase_e      phase;
  tf_ev_t      ev;

  always_comb begin
    wr_ok      = en_q && reg_wr;
    rd_ok      = en_q && reg_rd;
    bsy        = (phase == PH_BUSY);
    pkt_phase  = (phase == PH_PKT);
    din_phase  = (phase == PH_DIN);
    cmd_go     = wr_ok && (reg_addr == A_STAT) && !bsy;
    pkt_wr_go  = wr_ok && (reg_addr == A_DATA) && pkt_phase;
    din_rd_go  = rd_ok && (reg_addr == A_DATA) && din_phase;
    stat_rd_go = rd_ok && (reg_addr == A_STAT);
    alt_rd_go  = rd_ok && (reg_addr == A_ALT);
  end

  atapi_seq #(.BLK_BYTES(BLK_BYTES), .BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_code(reg_wdata[7:0]),
    .feat(feat_q), .pkt_wr_go(pkt_wr_go), .din_rd_go(din_rd_go),
    .wdata(reg_wdata), .resp_fail(resp_fail), .resp_len(resp_len),
    .phase(phase), .status(status), .widx(widx), .op(op),
    .len_hi(len_hi), .len_lo(len_lo), .ev(ev), .blk_bytes(blk_bytes),
    .irq_set(irq_set));

  atapi_resp #(.PATTERN(PATTERN)) u_resp (
    .op(op), .len_hi(len_hi), .len_lo(len_lo), .widx(widx),
    .fail(resp_fail), .sense(sense), .xfer_len(resp_len), .word(resp_word));

  atapi_taskfile u_tf (
    .clk(clk), .rst_n(rst_n), .host_wr(wr_ok && !bsy), .host_addr(reg_addr),
    .host_data(reg_wdata[7:0]), .ev(ev), .sense(sense), .blk_bytes(blk_bytes),
    .err_q(err_q), .feat_q(feat_q), .cnt_q(cnt_q), .bcl_q(bcl_q),
    .bch_q(bch_q), .dev_q(dev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      intrq <= 1'b0;
    end else begin
      if (cfg_wr) en_q <= (cfg_data == ENABLE_KEY);
      if (irq_set)                  intrq <= 1'b1;
      else if (stat_rd_go || cmd_go) intrq <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_DATA:        mux_data = din_phase ? resp_word : 16'hFFFF;
      A_ERR:         mux_data = {8'h00, err_q};
      A_CNT:         mux_data = {8'h00, cnt_q};
      A_BCL:         mux_data = {8'h00, bcl_q};
      A_BCH:         mux_data = {8'h00, bch_q};
      A_DEV:         mux_data = {8'h00, dev_q};
      default:       mux_data = {8'h00, status};
    endcase
    reg_rdata = en_q ? mux_data : 16'hFFFF;
  end
endmodule

// File: rtl/atapi_dev_ctrl_chk.sv
module atapi_dev_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        cmd_go,
  input logic        bsy,
  input logic        pkt_phase,
  input logic        din_phase,
  input logic [7:0]  status,
  input logic        intrq,
  input logic        irq_set,
  input logic        stat_rd_go,
  input logic        alt_rd_go,
  input logic [15:0] widx
);
  assert_pkt_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && reg_wdata[7:0] == 8'hA0 |=> status == 8'h58 && !intrq);
  assert_pkt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_phase |-> !intrq);
  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && reg_wdata[7:0] == 8'h08 |=> status == 8'h00 && !intrq);
  assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bsy && en_q && reg_wr && reg_addr == 3'd6 && reg_wdata[7:0] == 8'h08
    |=> status != 8'h00);
  assert_stat_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_go && !irq_set |=> !intrq);
  assert_alt_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    alt_rd_go && !irq_set && !cmd_go |=> $stable(intrq));
  assert_no_advance_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !din_phase && !pkt_phase |=> $stable(widx));
endmodule

bind atapi_dev_ctrl atapi_dev_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_go(cmd_go), .bsy(bsy), .pkt_phase(pkt_phase),
  .din_phase(din_phase), .status(status), .intrq(intrq), .irq_set(irq_set),
  .stat_rd_go(stat_rd_go), .alt_rd_go(alt_rd_go), .widx(widx));

// File: tb/sim_atapi_dev_ctrl.sv
module sim_atapi_dev_ctrl;
  localparam int CLK_NS = 10;
  localparam logic [15:0] PAT = 16'hA5C3;
  localparam logic [31:0] KEY = 32'h5A5A_0001;
  localparam int BLK = 2048;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, cfg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic [31:0] cfg_data = 32'h0;
  logic        intrq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  atapi_dev_ctrl #(.BUSY_CYC(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .intrq(intrq), .cfg_wr(cfg_wr), .cfg_data(cfg_data));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] d);
    @(negedge clk); cfg_data = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int i = 0; i < 60; i++) begin
      rd(3'd7, v);
      if (v[7] == 1'b0) break;
    end
  endtask

  task automatic expect_regs(input string req, input logic [7:0] st,
                             input logic [7:0] cn, input logic ir);
    logic [15:0] v;
    rd(3'd7, v); chk(req, v, {8'h00, st});
    rd(3'd2, v); chk(req, v, {8'h00, cn});
    chk(req, {15'h0, intrq}, {15'h0, ir});
  endtask

  // R1 and R2 checked on every packet
  task automatic send_pkt(input logic [7:0] op, input logic [15:0] len);
    logic [15:0] v;
    wr(3'd3, 16'h0008); wr(3'd4, 16'h0000);
    wr(3'd6, 16'h00A0);
    expect_regs("R1 packet phase", 8'h58, 8'h01, 1'b0);
    rd(3'd3, v); chk("R1 bcl kept", v, 16'h0008);
    rd(3'd4, v); chk("R1 bch kept", v, 16'h0000);
    wr(3'd0, {8'h00, op});
    wr(3'd0, {len[15:8], 8'h00});
    wr(3'd0, {8'h00, len[7:0]});
    wr(3'd0, 16'h0); wr(3'd0, 16'h0); wr(3'd0, 16'h0);
    rd(3'd7, v); chk("R2 busy after packet", v, 16'h00D0);
  endtask

  // drain a data transfer, checking R3 R4 R5 R6 R14
  task automatic drain(input int len);
    logic [15:0] v;
    int rem = len, k = 0, blk;
    wait_ready();
    while (rem > 0) begin
      blk = (rem > BLK) ? BLK : rem;
      chk("R4 intrq at block start", {15'h0, intrq}, 16'h1);
      rd(3'd7, v); chk("R3 status", v, 16'h0058);
      rd(3'd2, v); chk("R3 reason", v, 16'h0002);
      rd(3'd3, v); chk("R3 bcl", v, {8'h00, 8'(blk)});
      rd(3'd4, v); chk("R3 bch", v, {8'h00, 8'(blk >> 8)});
      rd(3'd6, v); chk("R12 status read clears", {15'h0, intrq}, 16'h0);
      for (int w = 0; w < blk / 2; w++) begin
        rd(3'd0, v); chk("R5 data word", v, 16'(k) ^ PAT);
        k++;
        if (w == blk / 4) chk("R4 intrq low mid block", {15'h0, intrq}, 16'h0);
      end
      rd(3'd0, v); chk("R14 data read in busy", v, 16'hFFFF);
      rem -= blk;
      wait_ready();
    end
    expect_regs("R6 completion", 8'h50, 8'h03, 1'b1);
    rd(3'd6, v);
    chk("R12 cleared after completion", {15'h0, intrq}, 16'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    int lens[7] = '{0, 2, 12, 2046, 2048, 2050, 5000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 power-on signature
    expect_regs("R8 power-on", 8'h00, 8'h01, 1'b0);
    rd(3'd1, v); chk("R8 error", v, 16'h0001);
    rd(3'd3, v); chk("R8 bcl", v, 16'h0014);
    rd(3'd4, v); chk("R8 bch", v, 16'h00EB);
    rd(3'd0, v); chk("R8 R14 data idle", v, 16'hFFFF);

    // R9 set features
    wr(3'd1, 16'h0003); wr(3'd2, 16'h000B); wr(3'd6, 16'h00EF);
    expect_regs("R9 set features 0B", 8'h50, 8'h0B, 1'b0);
    rd(3'd3, v); chk("R9 bcl", v, 16'h0000);
    rd(3'd4, v); chk("R9 bch", v, 16'h0000);
    wr(3'd2, 16'h0022); wr(3'd6, 16'h00EF);
    expect_regs("R9 set features 22", 8'h50, 8'h22, 1'b0);
    wr(3'd1, 16'h0005); wr(3'd6, 16'h00EF);
    expect_regs("R9 bad feature aborts", 8'h51, 8'h22, 1'b1);
    rd(3'd1, v); chk("R9 abort error", v, 16'h0004);
    rd(3'd6, v);

    // R10 unknown command
    wr(3'd6, 16'h0020);
    rd(3'd1, v); chk("R10 abort error", v, 16'h0004);
    rd(3'd7, v); chk("R10 abort status", v, 16'h0051);
    chk("R10 intrq", {15'h0, intrq}, 16'h1);
    rd(3'd7, v); chk("R12 alt read keeps intrq", {15'h0, intrq}, 16'h1);
    rd(3'd6, v); chk("R12 status read clears", {15'h0, intrq}, 16'h0);

    // R8 reset command
    wr(3'd6, 16'h0008);
    expect_regs("R8 reset cmd", 8'h00, 8'h01, 1'b0);
    rd(3'd1, v); chk("R8 reset error", v, 16'h0001);
    rd(3'd3, v); chk("R8 reset bcl", v, 16'h0014);
    rd(3'd4, v); chk("R8 reset bch", v, 16'h00EB);

    // R3 R4 R5 R6 length sweep
    for (int i = 0; i < 7; i++) begin
      send_pkt(8'h11 + 8'(i), 16'(lens[i]));
      drain(lens[i]);
    end
    // odd length rounds down (R5)
    send_pkt(8'h12, 16'd7);
    drain(6);

    // R7 sense key sweep
    for (int s = 0; s < 16; s++) begin
      send_pkt(8'hF0 | 8'(s), 16'd64);
      wait_ready();
      expect_regs("R7 error", 8'h51, 8'h03, 1'b1);
      rd(3'd1, v); chk("R7 sense key", v, {8'h00, 4'(s), 4'h0});
      rd(3'd6, v);
    end

    // R13 command ignored while busy; R14 data write ignored in DIN
    send_pkt(8'h30, 16'd4);
    wr(3'd6, 16'h0008);
    wait_ready();
    expect_regs("R13 reset ignored in busy", 8'h58, 8'h02, 1'b1);
    wr(3'd0, 16'h1234);
    rd(3'd6, v);
    rd(3'd0, v); chk("R14 word0 after data write", v, 16'h0000 ^ PAT);
    rd(3'd0, v); chk("R5 word1", v, 16'h0001 ^ PAT);
    wait_ready();
    expect_regs("R6 short done", 8'h50, 8'h03, 1'b1);
    rd(3'd6, v);

    // R11 disable / enable
    wr(3'd2, 16'h0042);
    cfg(32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R11 disabled read", v, 16'hFFFF);
    end
    wr(3'd2, 16'h0077);
    cfg(KEY);
    rd(3'd2, v); chk("R11 write ignored while off", v, 16'h0042);
    rd(3'd7, v); chk("R11 enabled again", v, 16'h0050);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule